// File: doc/BRIEF.md
# PWM Output Event Qualifier with Continuous Force

This block sits between a PWM time base and the output pins. Each clock the time base may raise four event strobes: counter at zero, counter at period, counter equal to compare A while counting up, and counter equal to compare B while counting up. A time-base tick qualifies them. For every channel a small table holds a 2-bit action for each event. The action can hold the pin, drive it low, drive it high or toggle it. Changing the codes for the zero, period and compare events produces normal-polarity or inverted waveforms.

Software can also pin a channel to a fixed level. The force request is written to a shadow copy first. It becomes active at a selectable point of the counting cycle: at zero, at period, at either of them, or on the next tick. While a force is active, the channel ignores every event.

Each channel is a four-state machine. ST_DRV_LO and ST_DRV_HI mean the events drive the pin, at low or high level. ST_FRC_LO and ST_FRC_HI mean a force holds the pin. Every transition happens only on a tick:
- SET_LOW, SET_HIGH and TOGGLE move between the two drive states.
- HOLD keeps the current drive state.
- FORCE_LOW and FORCE_HIGH enter a forced state from any state.
- RELEASE leaves a forced state for the drive state of the same level, unless an action applies on the same tick.

Top module: `pwm_evt_qual`

## Requirements
- R1: After reset both outputs are low, no force is active or pending, and all actions are "none". Unforced events after reset therefore leave both outputs low.
- R2: An action code is applied at the clock edge where `tb_tick` and its event strobe are both high, and it is visible right after that edge. The codes are 00 hold, 01 low, 10 high and 11 toggle.
- R3: The action register for channel A is at address 0 and the one for channel B is at address 1. Within each, bits 1:0 hold the zero action, bits 3:2 the period action, bits 5:4 the compare-A-up action and bits 9:8 the compare-B-up action.
- R4: Outputs and the active force setting change only on edges where `tb_tick` is high. Event strobes without a tick have no effect.
- R5: When several events fire on one tick, only events whose action is not 00 are considered. Among those, compare B wins over compare A, compare A wins over period, and period wins over zero.
- R6: The force register is at address 2, with bits 1:0 for channel A and bits 3:2 for channel B. Code 01 forces low, code 10 forces high, and 00 or 11 means no force. An active force overrides all event actions.
- R7: The reload select is in bits 1:0 at address 3. The shadow force value becomes active on the tick edge carrying the selected event: 00 zero, 01 period, 10 zero or period. On that same edge the new setting already governs the output.
- R8: With reload select 11, the new force setting takes effect on the first tick edge after the write. The forced level is visible right after that edge.
- R9: When a force is released on a tick with no applicable action, the output keeps the forced level until a later action changes it.
- R10: If the shadow is rewritten several times before the reload point, only the last value written becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base count enable; qualifies events and reloads |
| evt_zero | input | 1 | Counter reached zero |
| evt_period | input | 1 | Counter reached period |
| evt_cmpa_up | input | 1 | Counter equals compare A while counting up |
| evt_cmpb_up | input | 1 | Counter equals compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 action A, 1 action B, 2 force shadow, 3 reload select) |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 2 | PWM pins; bit 0 channel A, bit 1 channel B |

## Verification
A channel state machine stuck in the wrong state shows up on its pin right after the tick that should have moved it. Forced and driven states at the same level look identical, so the bench separates them: while a force is active it fires events whose actions would move the pin, and it releases forces on ticks with and without actions. A wrong active-force register or a bad reload decode appears at the first tick carrying the selected event. The bench probes every reload mode at a non-matching event and then at a matching one.

// File: rtl/pwm_evt_qual_pkg.sv
package pwm_evt_qual_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } evq_act_e;

    typedef enum logic [1:0] {
        RLD_AT_ZERO   = 2'b00,
        RLD_AT_PERIOD = 2'b01,
        RLD_AT_EITHER = 2'b10,
        RLD_NOW       = 2'b11
    } evq_rld_e;

    typedef enum logic [1:0] {
        ST_DRV_LO,
        ST_DRV_HI,
        ST_FRC_LO,
        ST_FRC_HI
    } evq_state_e;

    typedef struct packed {
        evq_act_e cmpb;
        evq_act_e cmpa;
        evq_act_e period;
        evq_act_e zero;
    } evq_actset_t;

    localparam logic [1:0] FRC_LOW  = 2'b01;
    localparam logic [1:0] FRC_HIGH = 2'b10;

    function automatic logic frc_on(input logic [1:0] code);
        return (code == FRC_LOW) || (code == FRC_HIGH);
    endfunction

endpackage

// File: rtl/pwm_evt_qual_regs.sv
module pwm_evt_qual_regs
    import pwm_evt_qual_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(NUM_CH + 2),
    localparam int FRC_W  = 2 * NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output evq_actset_t [NUM_CH-1:0] act_cfg,
    output logic [FRC_W-1:0]         frc_shadow,
    output evq_rld_e                 rld_sel
);

    localparam logic [ADDR_W-1:0] FRC_ADDR = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] RLD_ADDR = ADDR_W'(NUM_CH + 1);

    logic unused_wr;
    assign unused_wr = ^wr_data;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_act
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_cfg[ch] <= '{ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE};
            end else if (wr_en && wr_addr == ADDR_W'(ch)) begin
                act_cfg[ch].zero   <= evq_act_e'(wr_data[1:0]);
                act_cfg[ch].period <= evq_act_e'(wr_data[3:2]);
                act_cfg[ch].cmpa   <= evq_act_e'(wr_data[5:4]);
                act_cfg[ch].cmpb   <= evq_act_e'(wr_data[9:8]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frc_shadow <= '0;
            rld_sel    <= RLD_AT_ZERO;
        end else if (wr_en) begin
            if (wr_addr == FRC_ADDR) frc_shadow <= wr_data[FRC_W-1:0];
            if (wr_addr == RLD_ADDR) rld_sel    <= evq_rld_e'(wr_data[1:0]);
        end
    end

    AST_SHADOW_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == FRC_ADDR |=> frc_shadow == $past(wr_data[FRC_W-1:0])) else $error("shadow"); // R10

endmodule

// File: rtl/pwm_evt_qual_reload.sv
module pwm_evt_qual_reload
    import pwm_evt_qual_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int FRC_W = 2 * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt_zero,
    input  logic             evt_period,
    input  logic [FRC_W-1:0] frc_shadow,
    input  evq_rld_e         rld_sel,
    output logic [FRC_W-1:0] frc_eff
);

    logic [FRC_W-1:0] frc_active;
    logic             point_hit;
    logic             reload_now;

    always_comb begin
        unique case (rld_sel)
            RLD_AT_ZERO:   point_hit = evt_zero;
            RLD_AT_PERIOD: point_hit = evt_period;
            RLD_AT_EITHER: point_hit = evt_zero || evt_period;
            RLD_NOW:       point_hit = 1'b1;
            default:       point_hit = 1'b0;
        endcase
    end

    assign reload_now = tick && point_hit;
    assign frc_eff    = reload_now ? frc_shadow : frc_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frc_active <= '0;
        end else if (reload_now) begin
            frc_active <= frc_shadow;
        end
    end

    AST_ACTIVE_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(frc_active)) else $error("active moved"); // R4

    AST_IMMEDIATE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        tick && rld_sel == RLD_NOW |=> frc_active == $past(frc_shadow)) else $error("immediate"); // R8

    AST_ZERO_MODE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        rld_sel == RLD_AT_ZERO && !evt_zero |=> $stable(frc_active)) else $error("zero mode"); // R7

endmodule

// File: rtl/pwm_evt_qual_chan.sv
module pwm_evt_qual_chan
    import pwm_evt_qual_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        evt_zero,
    input  logic        evt_period,
    input  logic        evt_cmpa,
    input  logic        evt_cmpb,
    input  evq_actset_t cfg,
    input  logic [1:0]  frc,
    output logic        pwm
);

    evq_state_e state, state_nxt;
    evq_act_e   act;
    logic       level;

    // Lowest priority first, so later matches override earlier ones.
    always_comb begin
        act = ACT_NONE;
        if (evt_zero   && cfg.zero   != ACT_NONE) act = cfg.zero;
        if (evt_period && cfg.period != ACT_NONE) act = cfg.period;
        if (evt_cmpa   && cfg.cmpa   != ACT_NONE) act = cfg.cmpa;
        if (evt_cmpb   && cfg.cmpb   != ACT_NONE) act = cfg.cmpb;
    end

    assign level = (state == ST_DRV_HI) || (state == ST_FRC_HI);

    always_comb begin
        state_nxt = state;
        if (tick) begin
            if (frc == FRC_LOW) begin
                state_nxt = ST_FRC_LO;
            end else if (frc == FRC_HIGH) begin
                state_nxt = ST_FRC_HI;
            end else begin
                unique case (act)
                    ACT_NONE:   state_nxt = level ? ST_DRV_HI : ST_DRV_LO;
                    ACT_LOW:    state_nxt = ST_DRV_LO;
                    ACT_HIGH:   state_nxt = ST_DRV_HI;
                    ACT_TOGGLE: state_nxt = level ? ST_DRV_LO : ST_DRV_HI;
                    default:    state_nxt = state;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DRV_LO;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_DRV_LO: pwm = 1'b0;
            ST_DRV_HI: pwm = 1'b1;
            ST_FRC_LO: pwm = 1'b0;
            ST_FRC_HI: pwm = 1'b1;
            default:   pwm = 1'b0;
        endcase
    end

    AST_FORCE_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && frc == FRC_LOW |=> !pwm) else $error("force low"); // R6

    AST_FORCE_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && frc == FRC_HIGH |=> pwm) else $error("force high"); // R6

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm)) else $error("moved without tick"); // R4

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !frc_on(frc) && act == ACT_TOGGLE |=> pwm != $past(pwm)) else $error("toggle"); // R2

    AST_RELEASE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !frc_on(frc) && act == ACT_NONE |=> $stable(pwm)) else $error("release level"); // R9

endmodule

// File: rtl/pwm_evt_qual.sv
module pwm_evt_qual
    import pwm_evt_qual_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(NUM_CH + 2),
    localparam int FRC_W  = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_tick,
    input  logic              evt_zero,
    input  logic              evt_period,
    input  logic              evt_cmpa_up,
    input  logic              evt_cmpb_up,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_o
);

    evq_actset_t [NUM_CH-1:0] act_cfg;
    logic [FRC_W-1:0]         frc_shadow;
    logic [FRC_W-1:0]         frc_eff;
    evq_rld_e                 rld_sel;

    pwm_evt_qual_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .act_cfg    (act_cfg),
        .frc_shadow (frc_shadow),
        .rld_sel    (rld_sel)
    );

    pwm_evt_qual_reload #(.NUM_CH(NUM_CH)) u_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tb_tick),
        .evt_zero   (evt_zero),
        .evt_period (evt_period),
        .frc_shadow (frc_shadow),
        .rld_sel    (rld_sel),
        .frc_eff    (frc_eff)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwm_evt_qual_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tb_tick),
            .evt_zero   (evt_zero),
            .evt_period (evt_period),
            .evt_cmpa   (evt_cmpa_up),
            .evt_cmpb   (evt_cmpb_up),
            .cfg        (act_cfg[ch]),
            .frc        (frc_eff[2*ch +: 2]),
            .pwm        (pwm_o[ch])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk) $rose(rst_n) |-> pwm_o == '0) else $error("reset level"); // R1

endmodule

// File: tb/pwm_evt_qual_tb.sv
module pwm_evt_qual_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic        evt_zero = 1'b0;
    logic        evt_period = 1'b0;
    logic        evt_cmpa_up = 1'b0;
    logic        evt_cmpb_up = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_evt_qual u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tb_tick     (tb_tick),
        .evt_zero    (evt_zero),
        .evt_period  (evt_period),
        .evt_cmpa_up (evt_cmpa_up),
        .evt_cmpb_up (evt_cmpb_up),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_o       (pwm_o)
    );

    task automatic step(input logic t, input logic z, input logic p, input logic ca, input logic cb);
        @(negedge clk);
        tb_tick = t; evt_zero = z; evt_period = p; evt_cmpa_up = ca; evt_cmpb_up = cb;
        @(posedge clk);
        #1;
        tb_tick = 0; evt_zero = 0; evt_period = 0; evt_cmpa_up = 0; evt_cmpb_up = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic chk(input string req, input logic ea, input logic eb);
        n_chk++;
        if (pwm_o !== {eb, ea}) begin
            n_bad++;
            $display("FAIL %s: A/B actual %b/%b expected %b/%b", req, pwm_o[0], pwm_o[1], ea, eb);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset", 0, 0);
        step(1, 1, 1, 1, 1);
        chk("R1 no actions after reset", 0, 0);
    endtask

    task automatic t_actions();
        wr(2'd0, 16'h0312);   // A: zero high, cmpA low, cmpB toggle
        wr(2'd1, 16'h0039);   // B: zero low, period high, cmpA toggle
        step(1, 1, 0, 0, 0); chk("R2 R3 zero", 1, 0);
        step(1, 0, 1, 0, 0); chk("R2 R3 period", 1, 1);
        step(1, 0, 0, 1, 0); chk("R2 R3 cmpA", 0, 0);
        step(1, 0, 0, 0, 1); chk("R2 R3 cmpB", 1, 0);
    endtask

    task automatic t_no_tick();
        step(0, 1, 1, 1, 1); chk("R4 events without tick", 1, 0);
    endtask

    task automatic t_priority();
        step(1, 1, 1, 1, 0); chk("R5 cmpA over period over zero", 0, 1);
        step(1, 1, 1, 0, 0); chk("R5 period over zero, skip 00", 1, 1);
        step(1, 0, 0, 1, 0); chk("R5 setup", 0, 0);
        step(1, 0, 0, 1, 1); chk("R5 cmpB over cmpA", 1, 1);
    endtask

    task automatic t_reload_zero();
        wr(2'd2, 16'h0009);   // A low, B high
        step(1, 0, 1, 0, 0); chk("R7 zero mode waits", 1, 1);
        step(1, 1, 0, 0, 0); chk("R6 R7 load at zero", 0, 1);
        step(1, 1, 1, 1, 1); chk("R6 force overrides", 0, 1);
        wr(2'd2, 16'h0000);
        step(1, 0, 0, 1, 0); chk("R7 release pending", 0, 1);
        step(1, 1, 0, 0, 0); chk("R7 release at zero", 1, 0);
    endtask

    task automatic t_reload_period();
        wr(2'd3, 16'h0001);
        wr(2'd2, 16'h0001);
        step(1, 1, 0, 0, 0); chk("R7 period mode waits", 1, 0);
        step(1, 0, 1, 0, 0); chk("R7 load at period", 0, 1);
        wr(2'd2, 16'h0000);
        step(1, 0, 1, 0, 0); chk("R9 release keeps level", 0, 1);
    endtask

    task automatic t_reload_either();
        wr(2'd3, 16'h0002);
        wr(2'd2, 16'h0004);
        step(1, 1, 0, 0, 0); chk("R7 either at zero", 1, 0);
        wr(2'd2, 16'h0000);
        step(1, 0, 1, 0, 0); chk("R7 either release at period", 1, 1);
        wr(2'd2, 16'h0001);
        step(1, 0, 1, 0, 0); chk("R7 either load at period", 0, 1);
        wr(2'd2, 16'h0000);
        step(1, 1, 0, 0, 0); chk("R7 either release at zero", 1, 0);
    endtask

    task automatic t_immediate();
        wr(2'd3, 16'h0003);
        wr(2'd2, 16'h0005);
        step(0, 0, 0, 0, 0); chk("R8 R4 no tick no load", 1, 0);
        step(1, 0, 0, 0, 0); chk("R8 next tick forces", 0, 0);
        wr(2'd2, 16'h0000);
        step(1, 0, 0, 0, 0); chk("R9 immediate release holds", 0, 0);
        step(1, 0, 0, 0, 1); chk("R8 actions resume", 1, 0);
    endtask

    task automatic t_last_write();
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h0002);
        wr(2'd2, 16'h0001);
        step(1, 1, 0, 0, 0); chk("R10 last shadow wins", 0, 0);
        wr(2'd2, 16'h0000);
        step(1, 1, 0, 0, 0); chk("R10 release", 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_actions();
        t_no_tick();
        t_priority();
        t_reload_zero();
        t_reload_period();
        t_reload_either();
        t_immediate();
        t_last_write();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule